// File: doc/BRIEF.md
# Jittered current-mode PWM timing core

This block is the digital timing engine of a fixed-frequency, peak-current-mode switching controller. A free-running period counter, clocked by the system clock, starts a new switching period at every wrap. At each start the drive output is set and stays high until one of two things ends the pulse. The first is the external current-limit comparator, which is ignored during a blanking window just after turn-on. The second is a hard cap at four fifths of the period. A slow triangular dither moves the period length by up to 7.5 % around one of two nominal values, so the switching energy is spread over a band of frequencies.

A ramp-sync strobe marks the window in which the drive may be high. It starts the external slope-compensation current source. A soft-start counter rises linearly from zero after enable. The block outputs the smaller of this level and one third of the feedback code as the modulation-level code for the comparator threshold. When enable is low the block is quiet, and its dither and soft-start state return to their starting values.

Top module: `pwm_jitter_core`

## Requirements
- R1: With `fsel` = 0 the n-th period after enable (n from 0) lasts `PER_SLOW + d(n / JIT_DIV)` clocks, measured between rising edges of `ramp_sync`.
- R2: With `fsel` = 1 the same rule holds with `PER_FAST` as the nominal count.
- R3: The dither offset d(k) starts at 0 and first moves upward. It changes by exactly one per step and turns at ±floor(nominal·75/1000), so no period differs from nominal by more than that bound.
- R4: `drv` and `ramp_sync` both rise on the clock edge that starts each period.
- R5: If `cs_trip` is first seen high in the t-th clock of the on-time, with t > `LEB_CYC`, the drive falls after exactly t clocks high.
- R6: `cs_trip` is ignored during the first `LEB_CYC` on-clocks. A trip that is held from turn-on gives an on-time of `LEB_CYC`+1 clocks.
- R7: The on-time never exceeds floor(4·P/5) clocks, where P is that period's length. Without a trip it equals this value.
- R8: `ramp_sync` is high for exactly floor(4·P/5) clocks of every period, whatever `cs_trip` does.
- R9: After n enabled clocks the soft-start level is min(floor(n/`SS_STEP`), 2^`LVL_W`−1).
- R10: `mod_lvl` is a register. After each enabled edge it holds min(soft-start level before that edge, min(floor(`fb_code`/3), 2^`LVL_W`−1)).
- R11: While `en` is low, `drv`, `ramp_sync` and `mod_lvl` are 0 from the next edge on, whatever `cs_trip` does. On re-enable, soft-start restarts from 0 and the dither offset restarts from 0.
- R12: During and after reset with `en` low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low stops switching and clears soft-start |
| fsel | input | 1 | Nominal frequency choice: 0 slow count, 1 fast count |
| cs_trip | input | 1 | Current-limit comparator output, high when the sensed current exceeds the threshold |
| fb_code | input | FB_W | Feedback level code |
| drv | output | 1 | Switch drive |
| ramp_sync | output | 1 | Slope-compensation window, high from period start to the duty cap |
| mod_lvl | output | LVL_W | Modulation threshold code for the comparator |

## Verification
A wrong period counter or dither state shows up within one switching period. The spacing between `ramp_sync` rising edges then no longer matches the triangle sequence, and the `ramp_sync` width, which follows the period length, drifts with it. A wrong blanking or trip path shows in the `drv` high time of the very period in which the trip arrives. A soft-start level that is stuck or steps wrongly appears on `mod_lvl` one clock after the edge concerned, as long as the feedback code is not the smaller term.

// File: rtl/pwm_jitter_core.sv
module pwm_jitter_core #(
  parameter int PER_SLOW = 1538,
  parameter int PER_FAST = 1000,
  parameter int JIT_DIV  = 2,
  parameter int LEB_CYC  = 18,
  parameter int SS_STEP  = 1882,
  parameter int LVL_W    = 8,
  parameter int FB_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fsel,
  input  logic             cs_trip,
  input  logic [FB_W-1:0]  fb_code,
  output logic             drv,
  output logic             ramp_sync,
  output logic [LVL_W-1:0] mod_lvl
);

  localparam int DEV_SLOW = PER_SLOW * 75 / 1000;
  localparam int DEV_FAST = PER_FAST * 75 / 1000;
  localparam int PMAX = (PER_SLOW + DEV_SLOW > PER_FAST + DEV_FAST) ?
                        PER_SLOW + DEV_SLOW : PER_FAST + DEV_FAST;
  localparam int CW = $clog2(PMAX + 2);
  localparam int SW = CW + 1;
  localparam int JW = (JIT_DIV > 1) ? $clog2(JIT_DIV) : 1;
  localparam int PW = (SS_STEP > 1) ? $clog2(SS_STEP) : 1;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  logic                    run;
  logic [CW-1:0]           cnt, per, dmax;
  logic signed [SW-1:0]    ofs, nom_s, dev_s, per_s;
  logic                    up;
  logic [JW-1:0]           jdiv;
  logic [PW-1:0]           pre;
  logic [LVL_W-1:0]        ss, fb_sat;
  logic [FB_W-1:0]         fb3;
  logic [CW+1:0]           per4;
  logic                    wrap, duty_end, cs_cut;

  assign nom_s    = fsel ? SW'(PER_FAST) : SW'(PER_SLOW);
  assign dev_s    = fsel ? SW'(DEV_FAST) : SW'(DEV_SLOW);
  assign per_s    = nom_s + ofs;
  assign per4     = {per, 2'b00};
  assign dmax     = CW'(per4 / 3'd5);
  assign wrap     = !run || (cnt == per - 1'b1);
  assign duty_end = (cnt + 1'b1) == dmax;
  assign cs_cut   = cs_trip && (cnt >= CW'(LEB_CYC));
  assign fb3      = fb_code / 2'd3;
  assign fb_sat   = (int'(fb3) > int'(LVL_MAX)) ? LVL_MAX : LVL_W'(fb3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      per <= CW'(PER_SLOW);
      ofs <= '0;
      up <= 1'b1;
      jdiv <= '0;
      drv <= 1'b0;
      ramp_sync <= 1'b0;
    end else if (!en) begin
      run <= 1'b0;
      cnt <= '0;
      per <= CW'(PER_SLOW);
      ofs <= '0;
      up <= 1'b1;
      jdiv <= '0;
      drv <= 1'b0;
      ramp_sync <= 1'b0;
    end else begin
      run <= 1'b1;
      if (wrap) begin
        cnt <= '0;
        per <= CW'(per_s);
        drv <= 1'b1;
        ramp_sync <= 1'b1;
        if (jdiv == JW'(JIT_DIV - 1)) begin
          jdiv <= '0;
          if (up) begin
            if (ofs >= dev_s) begin
              up <= 1'b0;
              ofs <= ofs - SW'(1);
            end else begin
              ofs <= ofs + SW'(1);
            end
          end else begin
            if (ofs <= -dev_s) begin
              up <= 1'b1;
              ofs <= ofs + SW'(1);
            end else begin
              ofs <= ofs - SW'(1);
            end
          end
        end else begin
          jdiv <= jdiv + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (duty_end) begin
          drv <= 1'b0;
          ramp_sync <= 1'b0;
        end else if (cs_cut) begin
          drv <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      ss <= '0;
      mod_lvl <= '0;
    end else if (!en) begin
      pre <= '0;
      ss <= '0;
      mod_lvl <= '0;
    end else begin
      if (pre == PW'(SS_STEP - 1)) begin
        pre <= '0;
        if (ss != LVL_MAX) ss <= ss + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
      mod_lvl <= (ss < fb_sat) ? ss : fb_sat;
    end
  end

endmodule

// File: rtl/pwm_jitter_core_chk.sv
module pwm_jitter_core_chk #(
  parameter int PER_SLOW = 1538,
  parameter int PER_FAST = 1000,
  parameter int LEB_CYC  = 18,
  parameter int LVL_W    = 8,
  parameter int FB_W     = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [FB_W-1:0]  fb_code,
  input logic             drv,
  input logic             ramp_sync,
  input logic [LVL_W-1:0] mod_lvl
);

  localparam int DV_S = PER_SLOW * 75 / 1000;
  localparam int DV_F = PER_FAST * 75 / 1000;
  localparam int LO = (PER_SLOW - DV_S < PER_FAST - DV_F) ? PER_SLOW - DV_S : PER_FAST - DV_F;
  localparam int HI = (PER_SLOW + DV_S > PER_FAST + DV_F) ? PER_SLOW + DV_S : PER_FAST + DV_F;

  logic [15:0] on_len, gap;
  logic        ramp_q, seen, rise_now;

  assign rise_now = ramp_sync && !ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_len <= '0;
      gap <= '0;
      ramp_q <= 1'b0;
      seen <= 1'b0;
    end else begin
      ramp_q <= ramp_sync;
      on_len <= drv ? on_len + 16'd1 : 16'd0;
      if (rise_now) gap <= 16'd1;
      else gap <= gap + 16'd1;
      if (!en) seen <= 1'b0;
      else if (rise_now) seen <= 1'b1;
    end
  end

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!drv && !ramp_sync && mod_lvl == '0));

  // R7
  drv_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drv |-> ramp_sync);

  // R4
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv) |-> $rose(ramp_sync));

  // R6
  blank_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(drv) && ramp_sync) |-> (on_len >= 16'(LEB_CYC + 1)));

  // R3
  period_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_now && seen) |-> (gap >= 16'(LO) && gap <= 16'(HI)));

  // R9
  ss_slope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fb_code) == $past(fb_code, 2)) |->
      ({1'b0, mod_lvl} <= {1'b0, $past(mod_lvl)} + 1'b1));

endmodule

bind pwm_jitter_core pwm_jitter_core_chk #(
  .PER_SLOW(PER_SLOW), .PER_FAST(PER_FAST), .LEB_CYC(LEB_CYC),
  .LVL_W(LVL_W), .FB_W(FB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .fb_code(fb_code),
  .drv(drv), .ramp_sync(ramp_sync), .mod_lvl(mod_lvl)
);

// File: tb/sim_pwm_jitter_core.sv
module sim_pwm_jitter_core;
  localparam int PS = 40, PF = 27, JD = 2, LEB = 4, SS = 20, LW = 4, FW = 6;
  localparam int DVS = PS * 75 / 1000;
  localparam int DVF = PF * 75 / 1000;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, fsel = 1'b0, cs_trip = 1'b0;
  logic [FW-1:0] fb = '0;
  logic drv, ramp;
  logic [LW-1:0] lvl;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_jitter_core #(.PER_SLOW(PS), .PER_FAST(PF), .JIT_DIV(JD), .LEB_CYC(LEB),
                    .SS_STEP(SS), .LVL_W(LW), .FB_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .fsel(fsel), .cs_trip(cs_trip),
    .fb_code(fb), .drv(drv), .ramp_sync(ramp), .mod_lvl(lvl));

  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction

  function automatic int tri_at(int m, int dev);
    int t = 0;
    bit up = 1'b1;
    for (int k = 0; k < m; k++) begin
      if (up) begin
        if (t >= dev) begin up = 1'b0; t--; end else t++;
      end else begin
        if (t <= -dev) begin up = 1'b1; t++; end else t--;
      end
    end
    return t;
  endfunction

  function automatic int exp_per(int i, bit fs);
    return (fs ? PF : PS) + tri_at(i / JD, fs ? DVF : DVS);
  endfunction

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quiet_check(string req);
    check(drv == 1'b0, req, drv, 0);
    check(ramp == 1'b0, req, ramp, 0);
    check(lvl == '0, req, lvl, 0);
  endtask

  task automatic run_pwm(bit fs, int ncyc, bit trip);
    int i = -1, plen = 0, rlen = 0, dlen = 0, tgt = 0, dm = 0, ep = 0, edw = 0, nom = 0, dev = 0;
    bit pr = 1'b0;
    string tag;
    nom = fs ? PF : PS;
    dev = fs ? DVF : DVS;
    fsel = fs;
    cs_trip = 1'b0;
    en = 1'b1;
    while (i < ncyc) begin
      tick();
      if (ramp && !pr) begin
        check(drv == 1'b1, "R4", drv, 1);
        if (i >= 0) begin
          ep = exp_per(i, fs);
          check(plen == ep, fs ? "R2" : "R1", plen, ep);
          check(plen >= nom - dev && plen <= nom + dev, "R3", plen, nom);
          check(rlen == dm, "R8", rlen, dm);
          edw = trip ? imin(dm, imax(tgt, LEB + 1)) : dm;
          if (!trip || tgt >= dm) tag = "R7";
          else if (tgt <= LEB) tag = "R6";
          else tag = "R5";
          check(dlen == edw, tag, dlen, edw);
        end
        i++;
        dm = exp_per(i, fs) * 4 / 5;
        plen = 1; rlen = 1; dlen = 1;
        tgt = trip ? int'($urandom_range(dm + 3, 1)) : 0;
      end else begin
        plen++;
        if (ramp) rlen++;
        if (drv) dlen++;
      end
      if (trip && drv && dlen == tgt) cs_trip = 1'b1;
      if (!drv) cs_trip = 1'b0;
      pr = ramp;
    end
    en = 1'b0;
    cs_trip = 1'b0;
    tick();
    quiet_check("R11");
  endtask

  task automatic ss_run(int nmax);
    int ssx, fl, e;
    logic [FW-1:0] fbe;
    fb = '1;
    en = 1'b1;
    for (int n = 1; n <= nmax; n++) begin
      fbe = fb;
      tick();
      ssx = imin((n - 1) / SS, LMAX);
      fl = imin(int'(fbe) / 3, LMAX);
      e = imin(ssx, fl);
      check(int'(lvl) == e, (fl < ssx) ? "R10" : "R9", lvl, e);
      cs_trip = $urandom_range(1, 0) == 1;
      if ($urandom_range(7, 0) == 0)
        fb = ($urandom_range(1, 0) == 0) ? '1 : FW'($urandom_range(63, 0));
    end
  endtask

  task automatic dis_hold(int n);
    en = 1'b0;
    for (int k = 0; k < n; k++) begin
      cs_trip = $urandom_range(1, 0) == 1;
      tick();
      quiet_check("R11");
    end
    cs_trip = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    fb = '1;
    repeat (3) tick();
    quiet_check("R12");
    rst_n = 1'b1;
    tick();
    tick();
    quiet_check("R12");
    run_pwm(1'b0, 40, 1'b0);
    run_pwm(1'b1, 40, 1'b0);
    run_pwm(1'b0, 60, 1'b1);
    run_pwm(1'b1, 60, 1'b1);
    ss_run(150);
    dis_hold(20);
    ss_run(SS * LMAX + 40);
    dis_hold(3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule